// File: doc/BRIEF.md
# Test-Frame Alignment and Bit-Error Counter

This block measures the bit error rate of a demodulated bit stream that carries a known test frame, repeated back to back, of NBIT bits. Demodulated bits arrive one whole frame per strobe. The block keeps the two most recent frames. It compares a sliding NBIT-bit window of those two frames with a loadable reference frame.

While the block is not aligned, every accepted frame starts a serial search. The search tries each window position, one per clock, and keeps the position with the fewest mismatches. When the best count is small enough, the block aligns. While aligned, each frame is checked in one cycle at the stored position. The mismatch count of each good frame is added to a saturating error total, and NBIT is added to a saturating bit total. A frame with too many mismatches drops the alignment and is not counted. The block only measures. Producing the test pattern is the job of the transmit side.

Top module: `bert_sync_counter`

## Requirements
- R1: After a synchronous reset, busy, overrun and locked are 0, and offset, frame_errs, err_total and bit_total are all zero.
- R2: Bit 0 of in_bits is the earliest bit of a frame. An accepted frame becomes the newer half of a two-frame buffer, and the previous newer half becomes the older half. The window at offset k is older-frame bits k..NBIT-1 followed by newer-frame bits 0..k-1.
- R3: When unlocked, an accepted frame starts a search over offsets 0..NBIT-1, one per clock, with busy high for exactly NBIT cycles. The search then reports in frame_errs the smallest mismatch count. It reports in offset the lowest offset that reaches that count, because only a strictly smaller count replaces the running minimum, which starts at NBIT. frame_errs never exceeds NBIT.
- R4: At the end of a search, locked becomes 1 if 20 × (minimum count) < NBIT, and otherwise stays 0.
- R5: When locked, an accepted frame is compared at the stored offset in a single busy cycle, and its count appears on frame_errs. locked falls if 10 × count > NBIT. The offset does not change.
- R6: A frame checked while locked that does not drop the lock adds its count to err_total and NBIT to bit_total. Search frames and frames that drop the lock add nothing.
- R7: A strobe that arrives while busy is ignored and leaves the buffer unchanged. It raises overrun for the following cycle. An accepted strobe leaves overrun low.
- R8: err_total and bit_total saturate at all-ones instead of wrapping.
- R9: tot_clr zeroes both totals on the next edge. If an accumulation falls in the same cycle, tot_clr takes priority over it.
- R10: ref_load stores ref_bits as the reference frame. All comparisons use the stored reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_load | input | 1 | Store ref_bits as reference |
| ref_bits | input | NBIT | Reference frame, bit 0 earliest |
| in_valid | input | 1 | Frame strobe |
| in_bits | input | NBIT | Demodulated frame, bit 0 earliest |
| tot_clr | input | 1 | Clear both totals |
| busy | output | 1 | Search or check in progress |
| overrun | output | 1 | Strobe dropped in previous cycle |
| locked | output | 1 | Alignment held |
| offset | output | $clog2(NBIT) | Chosen window offset |
| frame_errs | output | $clog2(NBIT+1) | Mismatch count of last evaluated frame |
| err_total | output | CNT_W | Saturating accumulated errors |
| bit_total | output | CNT_W | Saturating accumulated bits |

## Verification
Two functions can fall in the same cycle: a locked-frame accumulation and a totals clear. The bench strobes a clean frame while locked and raises tot_clr exactly on the edge where the one-cycle check completes. It then expects both totals to read zero while the lock and the frame count are unaffected. A second collision is a strobe that arrives while a search is running. The bench judges it from the overrun pulse, and from the mismatch count of the next frame, which would be large if the dropped frame had entered the buffer.

// File: rtl/bert_pkg.sv
package bert_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SCAN  = 2'd1,
        PH_CHECK = 2'd2
    } phase_e;

    // Acquire when mismatches are below one twentieth of the frame.
    function automatic logic acquire_ok(input int unsigned errs, input int unsigned nbit);
        return (errs * 20) < nbit;
    endfunction

    // Release when mismatches exceed one tenth of the frame.
    function automatic logic release_due(input int unsigned errs, input int unsigned nbit);
        return (errs * 10) > nbit;
    endfunction

endpackage

// File: rtl/bert_frame_buf.sv
module bert_frame_buf #(
    parameter int unsigned NBIT = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [NBIT-1:0]   frame_in,
    output logic [2*NBIT-1:0] buf_q
);
    // Lower half holds the older frame, upper half the newer one.
    always_ff @(posedge clk) begin
        if (rst)
            buf_q <= '0;
        else if (shift_en)
            buf_q <= {frame_in, buf_q[2*NBIT-1:NBIT]};
    end
endmodule

// File: rtl/bert_window_cmp.sv
module bert_window_cmp #(
    parameter int unsigned NBIT  = 32,
    parameter int unsigned OFF_W = 5,
    parameter int unsigned ERR_W = 6
) (
    input  logic [2*NBIT-1:0] buf_i,
    input  logic [NBIT-1:0]   ref_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ERR_W-1:0]  errs_o
);
    logic [NBIT-1:0] diff;

    assign diff = buf_i[off_i +: NBIT] ^ ref_i;

    always_comb begin
        errs_o = '0;
        for (int i = 0; i < int'(NBIT); i++)
            errs_o = errs_o + ERR_W'(diff[i]);
    end
endmodule

// File: rtl/bert_sat_acc.sv
module bert_sat_acc #(
    parameter int unsigned W     = 32,
    parameter int unsigned INC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     total
);
    logic [W:0] sum;

    assign sum = {1'b0, total} + (W+1)'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr)
            total <= '0;
        else if (add_en)
            total <= sum[W] ? {W{1'b1}} : sum[W-1:0];
    end
endmodule

// File: rtl/bert_sync_counter.sv
module bert_sync_counter #(
    parameter int unsigned NBIT  = 32,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned OFF_W = $clog2(NBIT),
    localparam int unsigned ERR_W = $clog2(NBIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_load,
    input  logic [NBIT-1:0]   ref_bits,
    input  logic              in_valid,
    input  logic [NBIT-1:0]   in_bits,
    input  logic              tot_clr,
    output logic              busy,
    output logic              overrun,
    output logic              locked,
    output logic [OFF_W-1:0]  offset,
    output logic [ERR_W-1:0]  frame_errs,
    output logic [CNT_W-1:0]  err_total,
    output logic [CNT_W-1:0]  bit_total
);
    import bert_pkg::*;

    phase_e            phase_q;
    logic [NBIT-1:0]   ref_q;
    logic [2*NBIT-1:0] win_buf;
    logic [OFF_W-1:0]  scan_idx;
    logic [OFF_W-1:0]  run_best;
    logic [ERR_W-1:0]  run_min;
    logic [OFF_W-1:0]  sel_off;
    logic [ERR_W-1:0]  cur_errs;
    logic              accept;
    logic              better;
    logic [ERR_W-1:0]  min_now;
    logic [OFF_W-1:0]  best_now;
    logic              drop_now;
    logic              acc_en;

    assign busy     = (phase_q != PH_IDLE);
    assign accept   = in_valid && !busy;
    assign sel_off  = (phase_q == PH_SCAN) ? scan_idx : offset;
    assign better   = cur_errs < run_min;
    assign min_now  = better ? cur_errs : run_min;
    assign best_now = better ? scan_idx : run_best;
    assign drop_now = release_due(32'(cur_errs), NBIT);
    assign acc_en   = (phase_q == PH_CHECK) && !drop_now;

    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= '0;
        else if (ref_load)
            ref_q <= ref_bits;
    end

    bert_frame_buf #(.NBIT(NBIT)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .shift_en (accept),
        .frame_in (in_bits),
        .buf_q    (win_buf)
    );

    bert_window_cmp #(.NBIT(NBIT), .OFF_W(OFF_W), .ERR_W(ERR_W)) u_cmp (
        .buf_i  (win_buf),
        .ref_i  (ref_q),
        .off_i  (sel_off),
        .errs_o (cur_errs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            scan_idx   <= '0;
            run_best   <= '0;
            run_min    <= ERR_W'(NBIT);
            offset     <= '0;
            frame_errs <= '0;
            locked     <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            overrun <= in_valid && busy;
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q  <= locked ? PH_CHECK : PH_SCAN;
                        scan_idx <= '0;
                        run_best <= '0;
                        run_min  <= ERR_W'(NBIT);
                    end
                end
                PH_SCAN: begin
                    run_min  <= min_now;
                    run_best <= best_now;
                    if (scan_idx == OFF_W'(NBIT - 1)) begin
                        offset     <= best_now;
                        frame_errs <= min_now;
                        locked     <= acquire_ok(32'(min_now), NBIT);
                        phase_q    <= PH_IDLE;
                    end else begin
                        scan_idx <= scan_idx + 1'b1;
                    end
                end
                PH_CHECK: begin
                    frame_errs <= cur_errs;
                    if (drop_now)
                        locked <= 1'b0;
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    bert_sat_acc #(.W(CNT_W), .INC_W(ERR_W)) u_err_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (tot_clr),
        .add_en (acc_en),
        .inc    (cur_errs),
        .total  (err_total)
    );

    bert_sat_acc #(.W(CNT_W), .INC_W(ERR_W)) u_bit_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (tot_clr),
        .add_en (acc_en),
        .inc    (ERR_W'(NBIT)),
        .total  (bit_total)
    );
endmodule

// File: rtl/bert_sync_counter_chk.sv
module bert_sync_counter_chk #(
    parameter int unsigned NBIT  = 32,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned ERR_W = $clog2(NBIT + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             tot_clr,
    input logic             busy,
    input logic             overrun,
    input logic             locked,
    input logic [ERR_W-1:0] frame_errs,
    input logic [CNT_W-1:0] err_total,
    input logic [CNT_W-1:0] bit_total
);
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && busy) |=> overrun);                                  // R7
    AST_NO_FALSE_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> !overrun);                                // R7
    AST_SCAN_STARTS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && !locked) |=> busy);                         // R3
    AST_CHECK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy && locked) |=> busy ##1 !busy);                // R5
    AST_ERRS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        frame_errs <= ERR_W'(NBIT));                                      // R3
    AST_LOCK_FROM_SCAN: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(busy));                                   // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        tot_clr |=> (err_total == '0 && bit_total == '0));                // R9
    AST_ERR_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !tot_clr |=> err_total >= $past(err_total));                      // R6
    AST_BITS_STEP: assert property (@(posedge clk) disable iff (rst)
        !tot_clr |=> (bit_total == $past(bit_total) ||
                      bit_total == $past(bit_total) + CNT_W'(NBIT) ||
                      bit_total == {CNT_W{1'b1}}));                       // R8
endmodule

bind bert_sync_counter bert_sync_counter_chk #(.NBIT(NBIT), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .tot_clr    (tot_clr),
    .busy       (busy),
    .overrun    (overrun),
    .locked     (locked),
    .frame_errs (frame_errs),
    .err_total  (err_total),
    .bit_total  (bit_total)
);

// File: tb/bert_sync_counter_tb.sv
module bert_sync_counter_tb;
    localparam int  CLK_P = 10;
    localparam int  NB    = 40;
    localparam int  CW    = 10;
    localparam int  OW    = $clog2(NB);
    localparam int  EW    = $clog2(NB + 1);
    localparam logic [NB-1:0] REF = 40'hD3_6A_E1_59_4B;

    typedef struct packed {
        logic [7:0] nflip;
        logic       exp_lock;
        logic [7:0] exp_errs;
        logic       acc;
    } vec_t;

    // Stream phase 13 aligns at offset 27; flips sit at frame bits below 27.
    localparam vec_t VEC [0:6] = '{
        '{8'd0, 1'b1, 8'd0, 1'b1},
        '{8'd4, 1'b1, 8'd4, 1'b1},
        '{8'd5, 1'b0, 8'd5, 1'b0},
        '{8'd2, 1'b0, 8'd2, 1'b0},
        '{8'd1, 1'b1, 8'd1, 1'b0},
        '{8'd1, 1'b1, 8'd1, 1'b1},
        '{8'd0, 1'b1, 8'd0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_load = 1'b0;
    logic [NB-1:0] ref_bits = '0;
    logic          in_valid = 1'b0;
    logic [NB-1:0] in_bits = '0;
    logic          tot_clr = 1'b0;
    logic          busy, overrun, locked;
    logic [OW-1:0] offset;
    logic [EW-1:0] frame_errs;
    logic [CW-1:0] err_total, bit_total;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_err = 0;
    int exp_bits = 0;

    always #(CLK_P/2) clk = ~clk;

    bert_sync_counter #(.NBIT(NB), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .ref_load(ref_load), .ref_bits(ref_bits),
        .in_valid(in_valid), .in_bits(in_bits), .tot_clr(tot_clr),
        .busy(busy), .overrun(overrun), .locked(locked), .offset(offset),
        .frame_errs(frame_errs), .err_total(err_total), .bit_total(bit_total)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [NB-1:0] mk_frame(input int ph, input int nflip);
        logic [NB-1:0] f;
        for (int j = 0; j < NB; j++)
            f[j] = REF[(j + ph) % NB] ^ (j < nflip);
        return f;
    endfunction

    task automatic send(input logic [NB-1:0] f);
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = f;
        @(negedge clk);
        in_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 locked", locked, 0);
        check("R1 overrun", overrun, 0);
        check("R1 offset", offset, 0);
        check("R1 errs", frame_errs, 0);
        check("R1 err_total", err_total, 0);
        check("R1 bit_total", bit_total, 0);

        ref_load = 1'b1; ref_bits = REF;
        @(negedge clk);
        ref_load = 1'b0; ref_bits = '0;

        // R10 / R3: all-zero buffer mismatches popcount(REF)=21 everywhere; tie keeps offset 0
        send('0);
        check("R10 errs vs stored ref", frame_errs, 21);
        check("R3 tie keeps lowest offset", offset, 0);
        check("R4 no lock at 21", locked, 0);

        // R3 busy duration for a search
        @(negedge clk);
        in_valid = 1'b1; in_bits = mk_frame(13, 0);
        @(negedge clk);
        in_valid = 1'b0;
        for (int c = 0; c < NB; c++) begin
            if (!busy) check("R3 busy during search", busy, 1);
            @(negedge clk);
        end
        check("R3 busy ends after NBIT cycles", busy, 0);

        send(mk_frame(13, 0));
        check("R2 offset for phase 13", offset, 27);
        check("R4 acquire at 0 errs", locked, 1);
        check("R3 min errs", frame_errs, 0);
        check("R6 search adds nothing", bit_total, 0);

        for (int i = 0; i < 7; i++) begin
            send(mk_frame(13, VEC[i].nflip));
            if (VEC[i].acc) begin
                exp_err  += VEC[i].nflip;
                exp_bits += NB;
            end
            check("R4/R5 lock after vector", locked, VEC[i].exp_lock);
            check("R3/R5 frame errs", frame_errs, VEC[i].exp_errs);
            check("R5 offset held", offset, 27);
            check("R6 err_total", err_total, exp_err);
            check("R6 bit_total", bit_total, exp_bits);
        end

        // R7: strobe during a search is dropped
        send(mk_frame(13, 5));
        check("R5 release at 5", locked, 0);
        @(negedge clk);
        in_valid = 1'b1; in_bits = mk_frame(13, 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_bits = '1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 overrun pulse", overrun, 1);
        while (busy) @(negedge clk);
        check("R7 overrun clears", overrun, 0);
        check("R7 search unaffected", frame_errs, 0);
        check("R4 relock", locked, 1);
        send(mk_frame(13, 0));
        exp_bits += NB;
        check("R7 dropped frame not buffered", frame_errs, 0);
        check("R6 bits after relock", bit_total, exp_bits);

        // R9: clear coincides with a locked accumulation
        @(negedge clk);
        in_valid = 1'b1; in_bits = mk_frame(13, 2);
        @(negedge clk);
        in_valid = 1'b0; tot_clr = 1'b1;
        @(negedge clk);
        tot_clr = 1'b0;
        check("R9 clear wins err", err_total, 0);
        check("R9 clear wins bits", bit_total, 0);
        check("R9 lock kept", locked, 1);
        check("R9 errs reported", frame_errs, 2);

        // R8: saturation of totals
        for (int i = 0; i < 25; i++) send(mk_frame(13, 0));
        check("R8 bits before saturation", bit_total, 1000);
        send(mk_frame(13, 1));
        check("R8 bits saturate", bit_total, 1023);
        check("R8 err adds", err_total, 1);
        send(mk_frame(13, 0));
        check("R8 bits stay saturated", bit_total, 1023);

        // R2: a different stream phase aligns at another offset
        send(mk_frame(13, 5));
        check("R5 release", locked, 0);
        send(mk_frame(5, 0));
        send(mk_frame(5, 0));
        check("R2 offset for phase 5", offset, 35);
        check("R4 lock phase 5", locked, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule